// File: doc/BRIEF.md
# Comparator Output Conditioning Unit

This unit cleans up the digital outputs of three analog comparators before the rest of the chip uses them. Each raw comparator bit is treated as asynchronous: it is brought into the clock domain by a two-flop synchroniser. Software can then invert it and pass it through a glitch filter with a programmable window. The result is a steady level output per channel.

Each channel also watches its conditioned level for a chosen kind of transition. The choice is any edge, rising only, falling only, or none. A matching transition sets a sticky interrupt flag. A small register-style port, with a write strobe, an address, write data and combinational read data, programs each channel's control word. The same port reads the flags and clears them with write-one-to-clear.

Top module: `cmp_cond_top`

## Requirements
- R1: After reset, every channel control word reads 0, and all level outputs and interrupt flags are 0.
- R2: Channel n's control word is at address n (n = 0..2) and reads back as written. Bit 0 is invert, bit 1 is filter enable, bits 3:2 are the edge select, bits 8:4 are the window code. Bits above 8 read as 0.
- R3: With the filter disabled, a change on a raw input appears on its level output at the third rising clock edge after the change. That is two synchroniser stages plus one output register.
- R4: With the invert bit set, the level output is the complement of the synchronised input.
- R5: With the filter enabled, the level output takes a new value at clock edge 2+W after the raw input changes and holds. W is the window code plus 3, for codes 0..29, and W is 32 for codes 30 and 31.
- R6: With the filter enabled, an input pulse shorter than W cycles causes no change on the level output and sets no flag. The window count restarts whenever the input matches the output again.
- R7: The edge select chooses which level transitions are detected: 0 = both, 1 = rising, 2 = falling, 3 = none.
- R8: A detected transition sets the channel's flag one clock after the level changes. The flag stays set until software writes 1 to the matching bit at address 3. Flag n is bit n, and flag bits read back at address 3.
- R9: When a transition is detected in the same cycle as a clear of that flag, the flag stays set.
- R10: Channels are independent: activity and configuration on one channel leave the other channels' levels and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raw_i | input | 3 | Raw asynchronous comparator outputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0..2 channel control, 3 flags) |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i (combinational) |
| level_o | output | 3 | Conditioned comparator levels |
| irq_flag_o | output | 3 | Sticky interrupt flags |

## Verification
The hardest case to reach is a level edge landing in the very cycle that software clears the flag. The bench counts the register stages from the raw input, two sync flops and the output register, and starts the clear write so that its strobe is sampled at the same clock edge that would set the flag. The filter window is swept over all 32 codes. For each code the bench first sends a pulse one cycle short of the window, then a held change, and checks the level on the cycle before and the cycle of the expected switch.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
  localparam int WIN_CODE_W = 5;
  localparam int MIN_WIN    = 3;
  localparam int MAX_WIN    = 32;
  localparam int MAX_CODE   = MAX_WIN - MIN_WIN;
  localparam int WIN_VAL_W  = $clog2(MAX_WIN + 1);
  localparam int CNT_W      = $clog2(MAX_WIN);

  typedef enum logic [1:0] {
    EDGE_ANY  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_OFF  = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic [WIN_CODE_W-1:0] win_code;
    edge_sel_e             edge_sel;
    logic                  filt_en;
    logic                  invert;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/cmp_sync2.sv
module cmp_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cmp_glitch_filter.sv
module cmp_glitch_filter #(
  parameter int CNT_W     = 5,
  parameter int WIN_VAL_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 d_i,
  input  logic                 en_i,
  input  logic [WIN_VAL_W-1:0] win_i,
  output logic                 lvl_o
);
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = CNT_W'(win_i - WIN_VAL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      lvl_q <= d_i;
      cnt_q <= '0;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;  // any return to the held value restarts the window
    end else if (cnt_q >= last_cnt) begin
      lvl_q <= d_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign lvl_o = lvl_q;

  AST_LVL_FROM_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(d_i))); // R3
  AST_FILT_FULL_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (lvl_q != $past(lvl_q))) |-> ($past(cnt_q) >= $past(last_cnt))); // R5
  AST_FILT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (d_i == lvl_q)) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/cmp_edge_flag.sv
module cmp_edge_flag
  import cmp_cond_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  edge_sel_e sel_i,
  input  logic      clr_i,
  output logic      flag_o
);
  logic prev_q, flag_q, rise, fall, hit;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_ANY:  hit = rise | fall;
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= (flag_q & ~clr_i) | hit;  // set beats clear
    end
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flag_q) && !$past(clr_i)) |-> flag_q); // R8
  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit) |=> flag_q); // R9
  AST_OFF_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EDGE_OFF && !flag_q) |=> !flag_q); // R7
endmodule

// File: rtl/cmp_cond_top.sv
module cmp_cond_top
  import cmp_cond_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] raw_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] level_o,
  output logic [NUM_CH-1:0] irq_flag_o
);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NUM_CH);

  chan_cfg_t   cfg_q [NUM_CH];
  logic [NUM_CH-1:0] sync_d, pol_d, clr;
  logic        unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CFG_W];
  assign clr = (wr_en_i && addr_i == FLAG_ADDR) ? wdata_i[NUM_CH-1:0] : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [WIN_VAL_W-1:0] win;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[c] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(c)) cfg_q[c] <= chan_cfg_t'(wdata_i[CFG_W-1:0]);
    end

    assign win = (int'(cfg_q[c].win_code) > MAX_CODE) ? WIN_VAL_W'(MAX_WIN)
               : WIN_VAL_W'(cfg_q[c].win_code) + WIN_VAL_W'(MIN_WIN);

    cmp_sync2 i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_i[c]),
      .q_o   (sync_d[c])
    );

    assign pol_d[c] = sync_d[c] ^ cfg_q[c].invert;

    cmp_glitch_filter #(.CNT_W(CNT_W), .WIN_VAL_W(WIN_VAL_W)) i_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pol_d[c]),
      .en_i  (cfg_q[c].filt_en),
      .win_i (win),
      .lvl_o (level_o[c])
    );

    cmp_edge_flag i_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (level_o[c]),
      .sel_i (cfg_q[c].edge_sel),
      .clr_i (clr[c]),
      .flag_o(irq_flag_o[c])
    );

    AST_WIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(win) >= MIN_WIN) && (int'(win) <= MAX_WIN)); // R5
    AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !($past(wr_en_i) && $past(addr_i) == ADDR_W'(c)) |-> $stable(cfg_q[c])); // R10
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (addr_i == ADDR_W'(c)) rdata_o = DATA_W'(cfg_q[c]);
    if (addr_i == FLAG_ADDR) rdata_o = DATA_W'(irq_flag_o);
  end
endmodule

// File: tb/test_cmp_cond_top.sv
module test_cmp_cond_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  raw = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  level, flag;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cmp_cond_top i_cmp_cond_top (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .level_o(level), .irq_flag_o(flag)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    edges(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    addr = a; #1;
    chk(rdata, exp, tag);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    // R1 reset state
    for (int c = 0; c < 3; c++) rd(2'(c), 16'h0, "R1 ctrl");
    rd(2'd3, 16'h0, "R1 flags");
    chk(16'(level), 16'h0, "R1 level");

    // R2 readback and layout
    wr(2'd0, 16'h01A5);
    rd(2'd0, 16'h01A5, "R2 readback");
    wr(2'd2, 16'hFFFF);
    rd(2'd2, 16'h01FF, "R2 upper bits");
    wr(2'd0, 16'h0);
    wr(2'd2, 16'h0);
    edges(6);
    wr(2'd3, 16'h7);
    rd(2'd3, 16'h0, "R8 cleared");

    // R5 R6 R10 window sweep on channel 0
    for (int code = 0; code < 32; code++) begin
      int w;
      w = (code > 29) ? 32 : code + 3;
      wr(2'd0, 16'((code << 4) | 2));
      raw[0] = 1'b0;
      edges(6);
      wr(2'd3, 16'h7);
      raw[0] = 1'b1;
      edges(w - 1);
      raw[0] = 1'b0;
      edges(w + 4);
      chk(16'(level[0]), 16'h0, "R6 short pulse level");
      chk(16'(flag[0]), 16'h0, "R6 short pulse flag");
      raw[0] = 1'b1;
      edges(1 + w);
      chk(16'(level[0]), 16'h0, "R5 before window");
      edges(1);
      chk(16'(level[0]), 16'h1, "R5 at window");
      edges(1);
      chk(16'(flag[0]), 16'h1, "R8 flag set");
      raw[0] = 1'b0;
      edges(w + 4);
      chk(16'(level[0]), 16'h0, "R5 return");
      chk(16'(level[2:1]), 16'h0, "R10 other levels");
      chk(16'(flag[2:1]), 16'h0, "R10 other flags");
      edges(3);
      chk(16'(flag[0]), 16'h1, "R8 sticky");
      wr(2'd3, 16'h1);
      chk(16'(flag[0]), 16'h0, "R8 clear");
    end

    // R3 R7 edge select on channel 1, filter off
    for (int sel = 0; sel < 4; sel++) begin
      wr(2'd1, 16'(sel << 2));
      raw[1] = 1'b0;
      edges(5);
      wr(2'd3, 16'h2);
      raw[1] = 1'b1;
      edges(2);
      chk(16'(level[1]), 16'h0, "R3 before third edge");
      edges(1);
      chk(16'(level[1]), 16'h1, "R3 third edge");
      edges(1);
      chk(16'(flag[1]), 16'((sel == 0) || (sel == 1)), "R7 rising");
      wr(2'd3, 16'h2);
      raw[1] = 1'b0;
      edges(4);
      chk(16'(flag[1]), 16'((sel == 0) || (sel == 2)), "R7 falling");
      wr(2'd3, 16'h2);
    end

    // R4 polarity on channel 2
    wr(2'd2, 16'h1);
    edges(3);
    chk(16'(level[2]), 16'h1, "R4 inverted low");
    raw[2] = 1'b1;
    edges(3);
    chk(16'(level[2]), 16'h0, "R4 inverted high");
    chk(16'(level[1:0]), 16'h0, "R10 others during R4");
    wr(2'd3, 16'h4);

    // R9 clear in the same cycle as a detected edge
    wr(2'd1, 16'h0);
    raw[1] = 1'b0;
    edges(5);
    wr(2'd3, 16'h2);
    chk(16'(flag[1]), 16'h0, "R9 precondition");
    raw[1] = 1'b1;
    edges(3);
    wr(2'd3, 16'h2);
    chk(16'(flag[1]), 16'h1, "R9 set wins");
    wr(2'd3, 16'h2);
    chk(16'(flag[1]), 16'h0, "R8 later clear");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule